// File: doc/BRIEF.md
# Consecutive-Window PLL Lock Detector

This block judges whether a phase-locked loop has settled. Once per comparison cycle an upstream measurement stage presents a signed phase error, counted in fast sample-clock ticks, together with a valid strobe. The detector checks whether the error's magnitude sits inside a programmable tick window. It keeps a run count of consecutive in-window samples, and it raises a lock flag once that run reaches a threshold.

A single precision input selects the threshold: a short run of 24 samples or a stricter run of 40. Power-down clears the detector, and so does any change of the precision input, so a lock decision is never carried across a change of operating state. Any out-of-window sample drops lock at once.

Top module: `pll_lock_det`

## Requirements
- R1: While rst_ni is low, lock_o is 0. After reset is released the run count starts from zero.
- R2: A sample is in-window when err_vld_i is 1 and |err_i| <= win_i. Here err_i is a two's-complement signed tick count and win_i is an unsigned tick count. The most negative err_i value is out of window for any win_i.
- R3: With prec_i = 0, lock_o goes to 1 in the cycle after the clock edge that samples the 24th consecutive in-window sample. After 23 such samples it is still 0.
- R4: With prec_i = 1, lock_o goes to 1 after the 40th consecutive in-window sample. After 39 such samples it is still 0.
- R5: A valid out-of-window sample clears the run count and drives lock_o to 0 in the next cycle.
- R6: Cycles with err_vld_i = 0 leave the run count and lock_o unchanged, whatever err_i and win_i hold.
- R7: The run count saturates at the threshold, and lock_o stays 1 for as long as in-window samples continue.
- R8: While pd_i is 1, the run count is held at zero and lock_o is 0. Samples presented while pd_i is 1 are ignored.
- R9: A change of prec_i clears the run count and lock_o. The sample presented in that same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_i | input | 1 | Power-down; clears and holds the detector |
| prec_i | input | 1 | Precision select: 0 = 24-sample run, 1 = 40-sample run |
| win_i | input | WIN_W | Window half-width in ticks |
| err_vld_i | input | 1 | Phase error strobe, one per comparison cycle |
| err_i | input | ERR_W | Signed phase error in ticks |
| lock_o | output | 1 | Lock flag |

## Verification
The bench builds the block with its default parameters: a 10-bit error, a 6-bit window and thresholds of 24 and 40. At these values both lock thresholds are reached within a few dozen cycles, so every run boundary is exercised exactly, one sample short and one sample long. The 10-bit error width also lets the bench drive the most negative value, -512, which checks the magnitude corner. A 5-tick window keeps the edge values ±5 and ±6 at hand for both signs.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  localparam int unsigned ERR_W_DEF  = 10;
  localparam int unsigned WIN_W_DEF  = 6;
  localparam int unsigned THR_LO_DEF = 24;
  localparam int unsigned THR_HI_DEF = 40;
endpackage

// File: rtl/pll_lock_win.sv
module pll_lock_win #(
  parameter int unsigned ERR_W = pll_lock_pkg::ERR_W_DEF,
  parameter int unsigned WIN_W = pll_lock_pkg::WIN_W_DEF
) (
  input  logic signed [ERR_W-1:0] err_i,
  input  logic        [WIN_W-1:0] win_i,
  output logic                    good_o
);
  localparam int unsigned MAG_W = ERR_W + 1;

  logic signed [MAG_W-1:0] ext;
  logic        [MAG_W-1:0] mag;
  logic        [MAG_W-1:0] win_ext;

  // extra bit so the most negative error keeps its true magnitude
  always_comb begin
    ext     = MAG_W'(err_i);
    mag     = (ext < 0) ? MAG_W'(-ext) : MAG_W'(ext);
    win_ext = MAG_W'(win_i);
    good_o  = (mag <= win_ext);
  end
endmodule

// File: rtl/pll_lock_mode.sv
module pll_lock_mode #(
  parameter int unsigned THR_LO = pll_lock_pkg::THR_LO_DEF,
  parameter int unsigned THR_HI = pll_lock_pkg::THR_HI_DEF,
  localparam int unsigned CNT_W = $clog2(THR_HI + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prec_i,
  output logic             restart_o,
  output logic [CNT_W-1:0] thr_o
);
  logic prec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prec_q <= 1'b0;
    else         prec_q <= prec_i;
  end

  assign restart_o = (prec_i != prec_q);
  assign thr_o     = prec_i ? CNT_W'(THR_HI) : CNT_W'(THR_LO);

  assert_restart_once_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> (prec_q == $past(prec_i)));
endmodule

// File: rtl/pll_lock_run.sv
module pll_lock_run #(
  parameter int unsigned THR_HI = pll_lock_pkg::THR_HI_DEF,
  localparam int unsigned CNT_W = $clog2(THR_HI + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             vld_i,
  input  logic             good_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             lock_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             lock_q;

  assign cnt_inc = (cnt_q >= thr_i) ? thr_i : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (vld_i) begin
      if (good_i) begin
        cnt_q  <= cnt_inc;
        lock_q <= (cnt_inc == thr_i);
      end else begin
        cnt_q  <= '0;
        lock_q <= 1'b0;
      end
    end
  end

  assign lock_o = lock_q;

  assert_bad_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !good_i) |=> (cnt_q == '0 && !lock_q));
  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !clr_i) |=> ($stable(cnt_q) && $stable(lock_q)));
  assert_lock_sticks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && vld_i && good_i && !clr_i) |=> lock_q);
  assert_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !lock_q));
  assert_no_overrun_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(THR_HI));
endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
  parameter int unsigned ERR_W  = pll_lock_pkg::ERR_W_DEF,
  parameter int unsigned WIN_W  = pll_lock_pkg::WIN_W_DEF,
  parameter int unsigned THR_LO = pll_lock_pkg::THR_LO_DEF,
  parameter int unsigned THR_HI = pll_lock_pkg::THR_HI_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pd_i,
  input  logic                    prec_i,
  input  logic        [WIN_W-1:0] win_i,
  input  logic                    err_vld_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic                    lock_o
);
  localparam int unsigned CNT_W = $clog2(THR_HI + 1);

  logic             good, restart, clr;
  logic [CNT_W-1:0] thr;

  pll_lock_win #(.ERR_W(ERR_W), .WIN_W(WIN_W)) u_win (
    .err_i  (err_i),
    .win_i  (win_i),
    .good_o (good)
  );

  pll_lock_mode #(.THR_LO(THR_LO), .THR_HI(THR_HI)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prec_i    (prec_i),
    .restart_o (restart),
    .thr_o     (thr)
  );

  assign clr = pd_i | restart;

  pll_lock_run #(.THR_HI(THR_HI)) u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .vld_i  (err_vld_i),
    .good_i (good),
    .thr_i  (thr),
    .lock_o (lock_o)
  );

  assert_zero_err_good_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i == '0) |-> good);
  assert_pd_unlock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !lock_o);
  assert_bad_unlock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_vld_i && !good) |=> !lock_o);
endmodule

// File: tb/sim_pll_lock_det.sv
`timescale 1ns/1ps
module sim_pll_lock_det;
  localparam int ERR_W = 10;
  localparam int WIN_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd = 1'b0, prec = 1'b0, vld = 1'b0;
  logic [WIN_W-1:0] win = 6'd5;
  logic signed [ERR_W-1:0] err = '0;
  logic lock;

  int checks = 0, errors = 0;
  int exp_cnt = 0;
  bit exp_lock = 0;
  bit m_prec = 0;
  string req = "R1";

  always #2.5 clk = ~clk;

  pll_lock_det u0 (
    .clk_i(clk), .rst_ni(rst_n), .pd_i(pd), .prec_i(prec), .win_i(win),
    .err_vld_i(vld), .err_i(err), .lock_o(lock)
  );

  // behavioural reference, updated at each edge from the inputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_cnt = 0; exp_lock = 0; m_prec = 0;
    end else begin
      int thr, mag;
      thr = prec ? 40 : 24;
      mag = (int'(err) < 0) ? -int'(err) : int'(err);
      if (pd || prec != m_prec) begin
        exp_cnt = 0; exp_lock = 0;
      end else if (vld) begin
        if (mag <= int'(win)) begin
          if (exp_cnt < thr) exp_cnt++;
          exp_lock = (exp_cnt == thr);
        end else begin
          exp_cnt = 0; exp_lock = 0;
        end
      end
      m_prec = prec;
    end
  end

  task automatic chk(input bit act, input bit expv, input string r);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s lock_o actual %0b expected %0b at %0t", r, act, expv, $time);
    end
  endtask

  task automatic step(input bit v, input int e);
    vld = v;
    err = ERR_W'(e);
    @(posedge clk);
    #1;
    chk(lock, exp_lock, req);
  endtask

  task automatic goods(input int n);
    for (int k = 0; k < n; k++) step(1'b1, (k % 11) - 5);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog lock_o actual %0b expected done", lock);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12;
    chk(lock, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;
    #1;

    req = "R3"; goods(23); chk(lock, 1'b0, "R3");
    goods(1); chk(lock, 1'b1, "R3");
    req = "R5"; step(1, 6); chk(lock, 1'b0, "R5");

    req = "R6"; goods(10);
    for (int k = 0; k < 20; k++) begin win = 6'd0; step(0, 300); end
    win = 6'd5;
    goods(13); chk(lock, 1'b0, "R6");
    goods(1); chk(lock, 1'b1, "R6");

    req = "R7"; goods(30); chk(lock, 1'b1, "R7");

    req = "R2"; step(1, -5); chk(lock, 1'b1, "R2");
    step(1, -6); chk(lock, 1'b0, "R2");
    goods(24); chk(lock, 1'b1, "R2");
    win = 6'd63; step(1, -512); chk(lock, 1'b0, "R2");
    win = 6'd5;

    req = "R4"; prec = 1'b1; step(1, 0); chk(lock, 1'b0, "R4");
    goods(39); chk(lock, 1'b0, "R4");
    goods(1); chk(lock, 1'b1, "R4");
    goods(5); chk(lock, 1'b1, "R7");

    req = "R9"; prec = 1'b0; step(1, 0); chk(lock, 1'b0, "R9");
    goods(23); chk(lock, 1'b0, "R9");
    goods(1); chk(lock, 1'b1, "R9");

    req = "R8"; pd = 1'b1; goods(5); chk(lock, 1'b0, "R8");
    pd = 1'b0; goods(23); chk(lock, 1'b0, "R8");
    goods(1); chk(lock, 1'b1, "R8");

    req = "R1"; rst_n = 1'b0; #1; chk(lock, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;
    goods(23); chk(lock, 1'b0, "R1");
    goods(1); chk(lock, 1'b1, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule